// File: doc/BRIEF.md
# Effective Address Sequencer

This unit resolves the effective address of one memory operand for an 8-bit processor with a 16-bit address space. A start pulse loads an addressing-mode code, the access kind (load or store), the two operand bytes that follow the opcode, and the current X and Y index values. Direct modes resolve without memory traffic. Indirect modes fetch a two-byte pointer through a synchronous byte-wide read port.

When the address is ready the unit raises a one-cycle done strobe. In that cycle it presents the 16-bit effective address and a penalty flag. The flag tells the instruction sequencer that an index addition carried into the high address byte, so a load must spend one extra cycle. Stores always take the longer fixed count, so the flag stays low for them.

Top module: `ea_seq`

## Requirements
- R1: While and directly after reset, `done`, `mem_rd`, `page_pen` are 0 and `ea` is 0x0000.
- R2: Mode codes 0 (absolute), 1 (absolute+X) and 2 (absolute+Y) give `ea` = {op_hi, op_lo}, plus zero, X or Y as a full 16-bit sum with carry into the high byte. `done` is high in the first cycle after the start edge.
- R3: Mode codes 3 (page zero), 4 (page zero+X) and 5 (page zero+Y) give `ea` high byte 0x00 and low byte op_lo plus zero, X or Y modulo 256. `done` is high in the first cycle after the start edge.
- R4: For loads (`is_store`=0), `page_pen` is 1 exactly when the mode is 1, 2 or 8 and the high byte of the final address differs from the high byte of the unindexed base. In every other mode it is 0.
- R5: For stores (`is_store`=1), `page_pen` is 0 in every mode, including when a page is crossed.
- R6: Mode codes 6 (page-zero pointer), 7 (page-zero pointer at op_lo+X mod 256) and 8 (page-zero pointer, then +Y) read the low byte at {0x00, p} and the high byte at {0x00, p+1 mod 256}. `ea` is {high, low}, with Y added as a 16-bit sum in mode 8.
- R7: Mode codes 9 (absolute pointer) and 10 (absolute pointer+X) form the 16-bit pointer {op_hi, op_lo}, plus X in mode 10 with full carry. The low byte is read at the pointer and the high byte at pointer+1 (16-bit), and `ea` is {high, low}.
- R8: An indirect mode makes exactly two reads, in the first and second cycles after the start edge. `mem_rd` is high for one cycle per read, and the byte returns in the following cycle. `done` is high in the fourth cycle after the start edge and never together with `mem_rd`.
- R9: `done` lasts one cycle. `ea` and `page_pen` change only in a cycle where `done` is high and hold their value until the next such cycle.
- R10: A start pulse while an indirect resolution is in progress is ignored. The running result is unchanged, and no extra `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load a new request (accepted when idle) |
| mode_code | input | 4 | Addressing-mode code 0..10 |
| is_store | input | 1 | 1 for a store access, 0 for a load |
| op_lo | input | 8 | First operand byte |
| op_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index value |
| idx_y | input | 8 | Y index value |
| mem_addr | output | 16 | Pointer read address |
| mem_rd | output | 1 | Pointer read strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| done | output | 1 | One-cycle completion strobe |
| ea | output | 16 | Effective address |
| page_pen | output | 1 | Extra load cycle due to page crossing |

## Verification
The unit returns to idle in the same cycle that it raises `done`, so a new start can be accepted in the very cycle that the previous result is being presented. The bench provokes this by holding start high in the `done` cycle of a direct request. It then checks that the presented address still belongs to the old request and that the new result appears, with its own strobe, one cycle later. A start issued in the middle of a pointer fetch is also applied. The bench confirms that it neither disturbs the running result nor produces a second strobe.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int MODE_W = 4;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [MODE_W-1:0] {
        AM_ABS   = 4'd0,
        AM_ABSX  = 4'd1,
        AM_ABSY  = 4'd2,
        AM_ZP    = 4'd3,
        AM_ZPX   = 4'd4,
        AM_ZPY   = 4'd5,
        AM_ZIND  = 4'd6,
        AM_ZXIND = 4'd7,
        AM_ZINDY = 4'd8,
        AM_AIND  = 4'd9,
        AM_AXIND = 4'd10
    } amode_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_LO,
        ST_RD_HI,
        ST_LAST
    } seq_st_t;

    typedef struct packed {
        amode_t mode;
        logic   store;
        byte_t  lo;
        byte_t  hi;
        byte_t  x;
        byte_t  y;
    } req_t;

    typedef struct packed {
        addr_t ea;
        logic  pen;
    } res_t;

    function automatic logic is_indirect(amode_t m);
        return m inside {AM_ZIND, AM_ZXIND, AM_ZINDY, AM_AIND, AM_AXIND};
    endfunction

    function automatic logic is_zp_ptr(amode_t m);
        return m inside {AM_ZIND, AM_ZXIND, AM_ZINDY};
    endfunction

    function automatic logic is_zp_direct(amode_t m);
        return m inside {AM_ZP, AM_ZPX, AM_ZPY};
    endfunction

    function automatic logic pen_capable(amode_t m);
        return m inside {AM_ABSX, AM_ABSY, AM_ZINDY};
    endfunction

    // 16-bit base plus 8-bit index, with the penalty qualified by mode and access kind.
    function automatic res_t index_add(addr_t base, byte_t idx, amode_t m, logic store);
        res_t r;
        r.ea  = base + {{(ADDR_W-BYTE_W){1'b0}}, idx};
        r.pen = pen_capable(m) && !store && (r.ea[ADDR_W-1:BYTE_W] != base[ADDR_W-1:BYTE_W]);
        return r;
    endfunction

endpackage

// File: rtl/eag_direct.sv
module eag_direct
    import eag_pkg::*;
(
    input  amode_t mode,
    input  logic   store,
    input  byte_t  lo,
    input  byte_t  hi,
    input  byte_t  x,
    input  byte_t  y,
    output res_t   res
);
    byte_t zp_idx;

    always_comb begin
        zp_idx = '0;
        res    = '0;
        case (mode)
            AM_ABSX: res = index_add({hi, lo}, x, mode, store);
            AM_ABSY: res = index_add({hi, lo}, y, mode, store);
            AM_ZP, AM_ZPX, AM_ZPY: begin
                if (mode == AM_ZPX)      zp_idx = x;
                else if (mode == AM_ZPY) zp_idx = y;
                res.ea  = {{(ADDR_W-BYTE_W){1'b0}}, byte_t'(lo + zp_idx)};
                res.pen = 1'b0;
            end
            default: begin
                res.ea  = {hi, lo};
                res.pen = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/eag_ptr.sv
module eag_ptr
    import eag_pkg::*;
(
    input  amode_t mode,
    input  byte_t  lo,
    input  byte_t  hi,
    input  byte_t  x,
    output addr_t  ptr_lo,
    output addr_t  ptr_hi
);
    byte_t zp_p;
    addr_t abs_p;

    always_comb begin
        zp_p  = (mode == AM_ZXIND) ? byte_t'(lo + x) : lo;
        abs_p = (mode == AM_AXIND) ? ({hi, lo} + {{(ADDR_W-BYTE_W){1'b0}}, x}) : {hi, lo};
        if (is_zp_ptr(mode)) begin
            ptr_lo = {{(ADDR_W-BYTE_W){1'b0}}, zp_p};
            ptr_hi = {{(ADDR_W-BYTE_W){1'b0}}, byte_t'(zp_p + 1'b1)};
        end else begin
            ptr_lo = abs_p;
            ptr_hi = abs_p + 1'b1;
        end
    end
endmodule

// File: rtl/eag_final.sv
module eag_final
    import eag_pkg::*;
(
    input  amode_t mode,
    input  logic   store,
    input  byte_t  y,
    input  byte_t  ptr_lo_byte,
    input  byte_t  ptr_hi_byte,
    output res_t   res
);
    always_comb begin
        if (mode == AM_ZINDY) begin
            res = index_add({ptr_hi_byte, ptr_lo_byte}, y, mode, store);
        end else begin
            res.ea  = {ptr_hi_byte, ptr_lo_byte};
            res.pen = 1'b0;
        end
    end
endmodule

// File: rtl/ea_seq.sv
module ea_seq
    import eag_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [3:0]  mode_code,
    input  logic        is_store,
    input  logic [7:0]  op_lo,
    input  logic [7:0]  op_hi,
    input  logic [7:0]  idx_x,
    input  logic [7:0]  idx_y,
    output logic [15:0] mem_addr,
    output logic        mem_rd,
    input  logic [7:0]  mem_rdata,
    output logic        done,
    output logic [15:0] ea,
    output logic        page_pen
);
    seq_st_t st;
    req_t    req, new_req;
    byte_t   lo_q;
    addr_t   ea_q;
    logic    pen_q, done_q;
    res_t    dir_res, fin_res;
    addr_t   ptr_lo, ptr_hi;

    always_comb begin
        new_req.mode  = amode_t'(mode_code);
        new_req.store = is_store;
        new_req.lo    = op_lo;
        new_req.hi    = op_hi;
        new_req.x     = idx_x;
        new_req.y     = idx_y;
    end

    eag_direct u_direct (
        .mode (new_req.mode), .store(new_req.store),
        .lo   (new_req.lo),   .hi   (new_req.hi),
        .x    (new_req.x),    .y    (new_req.y),
        .res  (dir_res)
    );

    eag_ptr u_ptr (
        .mode  (req.mode), .lo(req.lo), .hi(req.hi), .x(req.x),
        .ptr_lo(ptr_lo),   .ptr_hi(ptr_hi)
    );

    eag_final u_final (
        .mode       (req.mode), .store(req.store), .y(req.y),
        .ptr_lo_byte(lo_q),     .ptr_hi_byte(mem_rdata),
        .res        (fin_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            req    <= '0;
            lo_q   <= '0;
            ea_q   <= '0;
            pen_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    req <= new_req;
                    if (is_indirect(new_req.mode)) begin
                        st <= ST_RD_LO;
                    end else begin
                        ea_q   <= dir_res.ea;
                        pen_q  <= dir_res.pen;
                        done_q <= 1'b1;
                    end
                end
                ST_RD_LO: st <= ST_RD_HI;
                ST_RD_HI: begin
                    lo_q <= mem_rdata;
                    st   <= ST_LAST;
                end
                default: begin
                    ea_q   <= fin_res.ea;
                    pen_q  <= fin_res.pen;
                    done_q <= 1'b1;
                    st     <= ST_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        mem_rd   = (st == ST_RD_LO) || (st == ST_RD_HI);
        mem_addr = (st == ST_RD_LO) ? ptr_lo : (st == ST_RD_HI) ? ptr_hi : '0;
    end

    assign done     = done_q;
    assign ea       = ea_q;
    assign page_pen = pen_q;

    // Fetch cycles and the completion strobe never overlap (R8).
    assert_rd_not_done_R8: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> !done);

    // The second pointer read follows the first at the next low-byte address (R6, R7).
    assert_ptr_step_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && $past(mem_rd)) |-> (mem_addr[7:0] == byte_t'($past(mem_addr[7:0]) + 1'b1)));

    // Page-zero pointer reads stay in page zero (R6).
    assert_zp_ptr_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && is_zp_ptr(req.mode)) |-> (mem_addr[15:8] == 8'h00));

    // Page-zero direct results stay in page zero (R3).
    assert_zp_result_R3: assert property (@(posedge clk) disable iff (rst)
        (done && is_zp_direct(req.mode)) |-> (ea[15:8] == 8'h00));

    // Stores never report the penalty (R5).
    assert_store_no_pen_R5: assert property (@(posedge clk) disable iff (rst)
        (done && req.store) |-> !page_pen);

    // Only the indexed-read modes can report the penalty (R4).
    assert_pen_modes_R4: assert property (@(posedge clk) disable iff (rst)
        (done && !pen_capable(req.mode)) |-> !page_pen);

    // Results hold outside the completion strobe (R9).
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(ea) && $stable(page_pen)));

endmodule

// File: tb/ea_seq_tb_top.sv
module ea_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [3:0]  mode_code;
    logic        is_store;
    logic [7:0]  op_lo, op_hi, idx_x, idx_y;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata;
    logic        done;
    logic [15:0] ea;
    logic        page_pen;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    ea_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .mode_code(mode_code), .is_store(is_store),
        .op_lo(op_lo), .op_hi(op_hi), .idx_x(idx_x), .idx_y(idx_y),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .done(done), .ea(ea), .page_pen(page_pen)
    );

    function automatic logic [7:0] memf(logic [15:0] a);
        logic [7:0] v;
        v = (a[7:0] * 8'd29) + (a[15:8] * 8'd7) + 8'h3C;
        return v;
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= memf(mem_addr);

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                fails++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                summary();
            end
        end
    end

    // Reference model from the requirements.
    task automatic model(input int m, input bit st, input logic [7:0] lo, hi, x, y,
                         output logic [15:0] e, output bit pen, output int lat,
                         output logic [15:0] r0, output logic [15:0] r1);
        logic [15:0] base, p;
        logic [7:0]  zp;
        pen = 0; lat = 1; r0 = 0; r1 = 0; base = {hi, lo}; e = base;
        case (m)
            1: e = base + {8'h00, x};
            2: e = base + {8'h00, y};
            3: e = {8'h00, lo};
            4: e = {8'h00, 8'(lo + x)};
            5: e = {8'h00, 8'(lo + y)};
            6, 7, 8: begin
                zp = (m == 7) ? 8'(lo + x) : lo;
                r0 = {8'h00, zp};
                r1 = {8'h00, 8'(zp + 8'd1)};
                base = {memf(r1), memf(r0)};
                e = (m == 8) ? base + {8'h00, y} : base;
                lat = 4;
            end
            9, 10: begin
                p  = (m == 10) ? base + {8'h00, x} : base;
                r0 = p;
                r1 = p + 16'd1;
                base = {memf(r1), memf(r0)};
                e = base;
                lat = 4;
            end
            default: e = base;
        endcase
        if ((m == 1 || m == 2 || m == 8) && !st && (e[15:8] != base[15:8])) pen = 1;
    endtask

    function automatic string mtag(int m);
        if (m <= 2) return "R2";
        if (m <= 5) return "R3";
        if (m <= 8) return "R6";
        return "R7";
    endfunction

    task automatic drive(input int m, input bit st, input logic [7:0] lo, hi, x, y);
        start = 1; mode_code = 4'(m); is_store = st;
        op_lo = lo; op_hi = hi; idx_x = x; idx_y = y;
    endtask

    task automatic run(input int m, input bit st, input logic [7:0] lo, hi, x, y);
        logic [15:0] e, r0, r1, ra0, ra1;
        bit pen;
        int lat, n, nrd;
        bit got;
        model(m, st, lo, hi, x, y, e, pen, lat, r0, r1);
        @(negedge clk);
        drive(m, st, lo, hi, x, y);
        n = 0; nrd = 0; got = 0; ra0 = 0; ra1 = 0;
        while (!got && n < 20) begin
            @(negedge clk);
            start = 0;
            n++;
            if (mem_rd) begin
                if (nrd == 0) ra0 = mem_addr;
                if (nrd == 1) ra1 = mem_addr;
                nrd++;
            end
            if (done) got = 1;
        end
        chk(got, "R8 done seen", int'(got), 1);
        chk(n == lat, (lat == 1) ? mtag(m) : "R8 latency", n, lat);
        chk(ea == e, mtag(m), ea, e);
        chk(page_pen == pen, st ? "R5" : "R4", page_pen, pen);
        if (lat == 4) begin
            chk(nrd == 2, "R8 read count", nrd, 2);
            chk(ra0 == r0, mtag(m), ra0, r0);
            chk(ra1 == r1, mtag(m), ra1, r1);
        end else begin
            chk(nrd == 0, "R2 no reads", nrd, 0);
        end
        @(negedge clk);
        chk(done == 0, "R9 one-cycle done", done, 0);
        chk(ea == e, "R9 hold", ea, e);
    endtask

    initial begin
        logic [15:0] e, r0, r1;
        bit pen;
        int lat;
        void'($urandom(32'd20240611));
        rst = 1; start = 0; mode_code = 0; is_store = 0;
        op_lo = 0; op_hi = 0; idx_x = 0; idx_y = 0;
        repeat (5) @(negedge clk);
        chk(done == 0 && mem_rd == 0 && page_pen == 0, "R1", {done, mem_rd, page_pen}, 0);
        chk(ea == 16'h0000, "R1", ea, 0);
        rst = 0;
        @(negedge clk);
        chk(done == 0 && ea == 0, "R1 after release", ea, 0);

        // Directed corner cases.
        run(0, 0, 8'h34, 8'h12, 8'h00, 8'h00);
        run(1, 0, 8'hF0, 8'h12, 8'h10, 8'h00);   // R4 crossing
        run(1, 0, 8'hF0, 8'h12, 8'h0F, 8'h00);   // R4 no crossing
        run(2, 1, 8'hFF, 8'h20, 8'h00, 8'h01);   // R5 store crossing
        run(2, 0, 8'hFF, 8'hFF, 8'h00, 8'h01);   // wraps whole space
        run(4, 0, 8'hF0, 8'h55, 8'h20, 8'h00);   // R3 wrap in page zero
        run(5, 0, 8'hFF, 8'hAA, 8'h00, 8'hFF);
        run(7, 0, 8'hFF, 8'h00, 8'h00, 8'h00);   // R6 pointer at 0xFF wraps to 0x00
        run(7, 0, 8'hF8, 8'h00, 8'h07, 8'h00);
        run(8, 0, 8'h10, 8'h00, 8'h00, 8'hFF);
        run(8, 1, 8'h10, 8'h00, 8'h00, 8'hFF);   // R5 store indirect-Y
        run(9, 0, 8'hFF, 8'h12, 8'h00, 8'h00);   // R7 pointer crossing page
        run(10, 0, 8'hFF, 8'hFF, 8'h01, 8'h00);  // R7 16-bit pointer wrap

        // Back-to-back: new start in the done cycle (R9, R2, R3).
        @(negedge clk);
        drive(1, 0, 8'h80, 8'h40, 8'h05, 8'h00);
        @(negedge clk);
        chk(done == 1 && ea == 16'h4085, "R2 first of pair", ea, 16'h4085);
        drive(4, 0, 8'hFE, 8'h99, 8'h03, 8'h00);
        @(negedge clk);
        start = 0;
        chk(done == 1, "R9 second strobe", done, 1);
        chk(ea == 16'h0001, "R3 second of pair", ea, 16'h0001);
        @(negedge clk);
        chk(done == 0, "R9 pair end", done, 0);

        // Start while busy is ignored (R10).
        model(9, 0, 8'h00, 8'h30, 8'h00, 8'h00, e, pen, lat, r0, r1);
        drive(9, 0, 8'h00, 8'h30, 8'h00, 8'h00);
        @(negedge clk);
        drive(0, 0, 8'h11, 8'h22, 8'h00, 8'h00);
        @(negedge clk);
        start = 0;
        @(negedge clk);
        chk(done == 0, "R10 no early done", done, 0);
        @(negedge clk);
        chk(done == 1 && ea == e, "R10 result kept", ea, e);
        begin
            int extra = 0;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                if (done) extra++;
            end
            chk(extra == 0 && ea == e, "R10 no extra done", extra, 0);
        end

        // Constrained random.
        for (int k = 0; k < 400; k++) begin
            int m;
            m = $urandom_range(0, 10);
            run(m, 1'($urandom_range(0, 1)), 8'($urandom), 8'($urandom),
                ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom), 8'($urandom));
        end

        summary();
    end
endmodule